// File: doc/BRIEF.md
# Keyed Deadman Timer

This block is a register-mapped deadman timer. Once software turns it on, it counts system clocks from zero towards a programmed period. Software keeps the system alive by restarting the count. A restart needs two key writes in order: an arming key, then a restart key. The restart key is taken only while the restart window is open, which covers the last part of the period.

A wrong arming key, a restart key written at the wrong time, or a count that reaches the period all end the run. The block raises an event status bit and drives a one-cycle pulse on `evt_o`. It also sets a sticky reset-cause bit, which a system reset controller or boot code can read later. The event and error bits stay set until the timer is switched off or the block is reset. The reset-cause bit survives a switch-off and is removed only through its clear alias.

The period and window registers hold counts of clock cycles. They can be written only while the timer is off. The timeout in seconds is the period divided by the clock rate.

Top module: `keyed_deadman`

## Requirements
- R1: After reset, control, count, status and reset-cause all read 0, `evt_o` is 0, and the period (0x60) and window (0x70) registers read DEF_PERIOD and DEF_WINDOW.
- R2: Writing control (0x00) with bit 15 set turns the timer on, and control then reads 0x8000. While it is on, the count (0x40) starts at 0 and rises by one per clock. Clearing bit 15 turns it off and returns the count to 0.
- R3: Writes to period (0x60) and window (0x70) take effect only while the timer is off. While it is on, such writes are ignored.
- R4: Status bit 0 reads 1 exactly when the timer is on and count >= period - window.
- R5: An arming write to 0x10 with bits 15:8 = 0x40, followed by a restart write to 0x20 with bits 7:0 = 0x08 while the window is open, sets the count to 0 and closes the window. It sets no status bit.
- R6: An arming write whose bits 15:8 differ from 0x40 sets status bit 7 (arming-key error).
- R7: A restart write sets status bit 6 (restart-key error) in any of these cases: no valid arming write came before it, its low byte is not 0x08, or the window is closed.
- R8: When the count reaches the period, or either key error is set, status bit 5 (event) sets and `evt_o` pulses high for exactly one cycle. The count then holds.
- R9: Status bits 5 to 7 clear only on reset or on turning the timer off. Key writes made while the timer is off have no effect.
- R10: Reset-cause bit 5 (read at 0x50) is set by every event. It stays set when the timer is turned off. A write to 0x54 with bit 5 set clears it.
- R11: In the cycle right after the timer is turned off, bus accesses are ignored: writes are dropped and reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| evt_o | output | 1 | One-cycle pulse when the event sets |

## Verification
The hardest case to reach from the ports is a valid key pair whose restart write falls inside the open window. The stimulus polls status bit 0 once per cycle until the window opens, then issues the arming and restart writes back to back and reads the count.

The second case that is hard to reach is the access that comes in the cycle right after the timer is turned off. To hit it, the bench holds the write strobe across two consecutive cycles: a switch-off write, then a period write. It samples the read data during the blocked cycle.

// File: rtl/dmt_pkg.sv
package dmt_pkg;
  localparam logic [7:0] OFS_CTRL      = 8'h00;
  localparam logic [7:0] OFS_ARM       = 8'h10;
  localparam logic [7:0] OFS_KICK      = 8'h20;
  localparam logic [7:0] OFS_STAT      = 8'h30;
  localparam logic [7:0] OFS_CNT       = 8'h40;
  localparam logic [7:0] OFS_CAUSE     = 8'h50;
  localparam logic [7:0] OFS_CAUSE_CLR = 8'h54;
  localparam logic [7:0] OFS_PERIOD    = 8'h60;
  localparam logic [7:0] OFS_WIN       = 8'h70;

  localparam logic [7:0] KEY_ARM  = 8'h40;
  localparam logic [7:0] KEY_KICK = 8'h08;

  localparam int EN_BIT    = 15;
  localparam int ST_WIN    = 0;
  localparam int ST_EVT    = 5;
  localparam int ST_BAD2   = 6;
  localparam int ST_BAD1   = 7;
  localparam int CAUSE_BIT = 5;
endpackage

// File: rtl/dmt_count.sv
module dmt_count #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             live,
  input  logic             halt,
  input  logic             restart,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] window,
  output logic [CNT_W-1:0] count_q,
  output logic             win_open,
  output logic             expired
);
  logic [CNT_W-1:0] count_d;
  logic [CNT_W-1:0] thresh;

  always_comb begin
    thresh = (window >= period) ? '0 : (period - window);
  end

  always_comb begin
    count_d = count_q;
    if (!live)                           count_d = '0;
    else if (restart)                    count_d = '0;
    else if (!halt && count_q < period)  count_d = count_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end

  assign win_open = live && (count_q >= thresh);
  assign expired  = live && (count_q >= period);

  // R8
  count_le_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= period);
  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !halt && !restart && count_q < period) |=> count_q == $past(count_q) + 1'b1);
  // R5
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && restart) |=> count_q == '0);
endmodule

// File: rtl/dmt_keychk.sv
module dmt_keychk
  import dmt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        live,
  input  logic        arm_wr,
  input  logic        kick_wr,
  input  logic [15:0] key_data,
  input  logic        win_open,
  output logic        kick_ok,
  output logic        bad1_q,
  output logic        bad2_q
);
  logic armed_q, armed_d, bad1_d, bad2_d, arm_good;

  assign arm_good = arm_wr && (key_data[15:8] == KEY_ARM);
  assign kick_ok  = kick_wr && armed_q && (key_data[7:0] == KEY_KICK) && win_open;

  always_comb begin
    armed_d = armed_q;
    bad1_d  = bad1_q;
    bad2_d  = bad2_q;
    if (!live) begin
      armed_d = 1'b0;
      bad1_d  = 1'b0;
      bad2_d  = 1'b0;
    end else begin
      if (kick_wr)       armed_d = 1'b0;
      else if (arm_good) armed_d = 1'b1;
      if (arm_wr && !arm_good) bad1_d = 1'b1;
      if (kick_wr && !kick_ok) bad2_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      bad1_q  <= 1'b0;
      bad2_q  <= 1'b0;
    end else begin
      armed_q <= armed_d;
      bad1_q  <= bad1_d;
      bad2_q  <= bad2_d;
    end
  end

  // R9
  bad1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && bad1_q) |=> bad1_q);
  // R9
  bad2_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && bad2_q) |=> bad2_q);
  // R6
  bad_arm_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && arm_wr && key_data[15:8] != KEY_ARM) |=> bad1_q);
  // R7
  early_kick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && kick_wr && !win_open) |=> bad2_q);
endmodule

// File: rtl/dmt_event.sv
module dmt_event (
  input  logic clk,
  input  logic rst_n,
  input  logic live,
  input  logic expired,
  input  logic bad1,
  input  logic bad2,
  input  logic cause_clr,
  output logic evt_q,
  output logic pulse_q,
  output logic cause_q
);
  logic fire, evt_d, cause_d;

  assign fire = live && !evt_q && (expired || bad1 || bad2);

  always_comb begin
    evt_d   = live ? (evt_q || fire) : 1'b0;
    cause_d = cause_q;
    if (fire)           cause_d = 1'b1;
    else if (cause_clr) cause_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q   <= 1'b0;
      pulse_q <= 1'b0;
      cause_q <= 1'b0;
    end else begin
      evt_q   <= evt_d;
      pulse_q <= fire;
      cause_q <= cause_d;
    end
  end

  // R8
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> !pulse_q);
  // R8
  pulse_with_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_q) |-> pulse_q);
  // R10
  cause_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_q && !cause_clr) |=> cause_q);
endmodule

// File: rtl/keyed_deadman.sv
module keyed_deadman
  import dmt_pkg::*;
#(
  parameter int CNT_W      = 32,
  parameter int DATA_W     = 32,
  parameter int DEF_PERIOD = 1000,
  parameter int DEF_WINDOW = 250
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [7:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              evt_o
);
  localparam logic [CNT_W-1:0] PERIOD_RST = CNT_W'(DEF_PERIOD);
  localparam logic [CNT_W-1:0] WINDOW_RST = CNT_W'(DEF_WINDOW);

  logic [1:0] rs_q;
  logic       arst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign arst_n = rs_q[1];

  logic             en_q, en_d, blk_q, blk_d;
  logic [CNT_W-1:0] period_q, period_d, win_q, win_d;
  logic             wr_ok, wr_ctrl, dis_req, live;
  logic             arm_wr, kick_wr, cause_clr;
  logic             kick_ok, bad1, bad2, evt, cause;
  logic [CNT_W-1:0] count;
  logic             win_open, expired;

  assign wr_ok   = bus_wr && !blk_q;
  assign wr_ctrl = wr_ok && (bus_addr == OFS_CTRL);
  assign dis_req = en_q && wr_ctrl && !bus_wdata[EN_BIT];
  assign live    = en_q && !dis_req;

  assign arm_wr    = wr_ok && live && !evt && (bus_addr == OFS_ARM);
  assign kick_wr   = wr_ok && live && !evt && (bus_addr == OFS_KICK);
  assign cause_clr = wr_ok && (bus_addr == OFS_CAUSE_CLR) && bus_wdata[CAUSE_BIT];

  always_comb begin
    en_d     = wr_ctrl ? bus_wdata[EN_BIT] : en_q;
    blk_d    = dis_req;
    period_d = period_q;
    win_d    = win_q;
    if (wr_ok && !en_q && bus_addr == OFS_PERIOD) period_d = bus_wdata[CNT_W-1:0];
    if (wr_ok && !en_q && bus_addr == OFS_WIN)    win_d    = bus_wdata[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      en_q     <= 1'b0;
      blk_q    <= 1'b0;
      period_q <= PERIOD_RST;
      win_q    <= WINDOW_RST;
    end else begin
      en_q     <= en_d;
      blk_q    <= blk_d;
      period_q <= period_d;
      win_q    <= win_d;
    end
  end

  dmt_count #(.CNT_W(CNT_W)) u_count (
    .clk      (clk),
    .rst_n    (arst_n),
    .live     (live),
    .halt     (evt),
    .restart  (kick_ok),
    .period   (period_q),
    .window   (win_q),
    .count_q  (count),
    .win_open (win_open),
    .expired  (expired)
  );

  dmt_keychk u_keys (
    .clk      (clk),
    .rst_n    (arst_n),
    .live     (live),
    .arm_wr   (arm_wr),
    .kick_wr  (kick_wr),
    .key_data (bus_wdata[15:0]),
    .win_open (win_open),
    .kick_ok  (kick_ok),
    .bad1_q   (bad1),
    .bad2_q   (bad2)
  );

  dmt_event u_event (
    .clk       (clk),
    .rst_n     (arst_n),
    .live      (live),
    .expired   (expired),
    .bad1      (bad1),
    .bad2      (bad2),
    .cause_clr (cause_clr),
    .evt_q     (evt),
    .pulse_q   (evt_o),
    .cause_q   (cause)
  );

  always_comb begin
    bus_rdata = '0;
    if (!blk_q) begin
      case (bus_addr)
        OFS_CTRL:   bus_rdata[EN_BIT] = en_q;
        OFS_STAT: begin
          bus_rdata[ST_WIN]  = win_open;
          bus_rdata[ST_EVT]  = evt;
          bus_rdata[ST_BAD2] = bad2;
          bus_rdata[ST_BAD1] = bad1;
        end
        OFS_CNT:    bus_rdata = DATA_W'(count);
        OFS_PERIOD: bus_rdata = DATA_W'(period_q);
        OFS_WIN:    bus_rdata = DATA_W'(win_q);
        OFS_CAUSE:  bus_rdata[CAUSE_BIT] = cause;
        default:    bus_rdata = '0;
      endcase
    end
  end

  // R3
  period_frozen_chk: assert property (@(posedge clk) disable iff (!arst_n)
    en_q |=> $stable(period_q) && $stable(win_q));
  // R11
  blocked_read_chk: assert property (@(posedge clk) disable iff (!arst_n)
    blk_q |-> bus_rdata == '0);
  // R11
  blocked_once_chk: assert property (@(posedge clk) disable iff (!arst_n)
    blk_q |=> !blk_q && !en_q);
endmodule

// File: tb/keyed_deadman_test.sv
module keyed_deadman_test;
  logic        clk;
  logic        rst_n;
  logic        bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        evt_o;

  int checks = 0;
  int fails  = 0;
  int pulses = 0;
  bit done   = 0;

  keyed_deadman uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .evt_o     (evt_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) if (evt_o) pulses <= pulses + 1;

  // {req[3:0], is_write, addr[7:0], wdata[31:0], expected[31:0]}
  localparam logic [76:0] VEC [13] = '{
    {4'd1,  1'b0, 8'h00, 32'h0,    32'h0},     // R1 control
    {4'd1,  1'b0, 8'h30, 32'h0,    32'h0},     // R1 status
    {4'd1,  1'b0, 8'h40, 32'h0,    32'h0},     // R1 count
    {4'd1,  1'b0, 8'h60, 32'h0,    32'd1000},  // R1 period default
    {4'd1,  1'b0, 8'h70, 32'h0,    32'd250},   // R1 window default
    {4'd1,  1'b0, 8'h50, 32'h0,    32'h0},     // R1 cause
    {4'd3,  1'b1, 8'h60, 32'd40,   32'h0},     // R3 set period
    {4'd3,  1'b1, 8'h70, 32'd10,   32'h0},     // R3 set window
    {4'd3,  1'b0, 8'h60, 32'h0,    32'd40},    // R3 readback
    {4'd3,  1'b0, 8'h70, 32'h0,    32'd10},    // R3 readback
    {4'd9,  1'b1, 8'h10, 32'h1200, 32'h0},     // R9 bad arm while off
    {4'd9,  1'b1, 8'h20, 32'h33,   32'h0},     // R9 bad kick while off
    {4'd9,  1'b0, 8'h30, 32'h0,    32'h0}      // R9 no flags
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    check(tag, bus_rdata, exp);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    bus_wr = 1'b0; bus_addr = 8'h0; bus_wdata = 32'h0;
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(3);
    check("R1 evt_o idle", {31'b0, evt_o}, 32'h0);

    for (int v = 0; v < 13; v++) begin
      if (VEC[v][72]) wr(VEC[v][71:64], VEC[v][63:32]);
      else rd($sformatf("R%0d vector %0d", VEC[v][76:73], v), VEC[v][71:64], VEC[v][31:0]);
    end

    // A: valid key pair inside the window
    wr(8'h00, 32'h8000);
    rd("R2 control on", 8'h00, 32'h8000);
    rd("R2 count start", 8'h40, 32'd0);
    for (int i = 0; i < 100; i++) begin
      bus_addr = 8'h30; #1;
      if (bus_rdata[0]) break;
      @(negedge clk);
    end
    rd("R4 window opens at 30", 8'h40, 32'd30);
    wr(8'h10, 32'h4000);
    wr(8'h20, 32'h08);
    rd("R5 count restarted", 8'h40, 32'd0);
    rd("R5 status clean", 8'h30, 32'h0);
    idle(1);
    rd("R2 count steps", 8'h40, 32'd1);
    check("R5 no pulse", pulses, 0);

    // B: restart key while window closed
    wr(8'h10, 32'h4000);
    wr(8'h20, 32'h08);
    idle(2);
    rd("R7 early kick", 8'h30, 32'h60);
    check("R8 one pulse", pulses, 1);
    rd("R10 cause set", 8'h50, 32'h20);
    begin
      logic [31:0] held;
      bus_addr = 8'h40; #1; held = bus_rdata;
      idle(3);
      rd("R8 count holds", 8'h40, held);
    end
    // turn off, then write in the very next cycle
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 8'h00; bus_wdata = 32'h0;
    @(negedge clk);
    bus_addr = 8'h60; bus_wdata = 32'd99;
    #1 check("R11 blocked read", bus_rdata, 32'h0);
    @(negedge clk);
    bus_wr = 1'b0;
    rd("R11 blocked write dropped", 8'h60, 32'd40);
    rd("R9 flags cleared by off", 8'h30, 32'h0);
    rd("R2 count zero when off", 8'h40, 32'h0);
    rd("R10 cause survives off", 8'h50, 32'h20);
    wr(8'h54, 32'h20);
    rd("R10 cause cleared", 8'h50, 32'h0);

    // C: wrong arming key
    wr(8'h00, 32'h8000);
    wr(8'h60, 32'd77);
    rd("R3 period locked while on", 8'h60, 32'd40);
    wr(8'h10, 32'h4100);
    idle(2);
    rd("R6 bad arm key", 8'h30, 32'hA0);
    check("R8 pulse on bad arm", pulses, 2);
    wr(8'h00, 32'h0);
    idle(1);

    // D: restart key with no arming, window open
    wr(8'h00, 32'h8000);
    idle(32);
    wr(8'h20, 32'h08);
    idle(2);
    rd("R7 kick without arm", 8'h30, 32'h61);
    check("R8 pulse on bad kick", pulses, 3);
    wr(8'h00, 32'h0);
    idle(1);

    // E: expiry
    wr(8'h00, 32'h8000);
    idle(29);
    rd("R4 window closed at 29", 8'h30, 32'h0);
    idle(1);
    rd("R4 window open at 30", 8'h30, 32'h1);
    idle(10);
    rd("R8 count at period", 8'h40, 32'd40);
    check("R8 no pulse yet", {31'b0, evt_o}, 32'h0);
    idle(1);
    check("R8 pulse high", {31'b0, evt_o}, 32'h1);
    rd("R8 event status", 8'h30, 32'h21);
    idle(1);
    check("R8 pulse one cycle", {31'b0, evt_o}, 32'h0);
    rd("R8 count stays", 8'h40, 32'd40);
    check("R8 pulse total", pulses, 4);
    rd("R10 cause after expiry", 8'h50, 32'h20);

    // F: reset in the middle of a run
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(3);
    rd("R1 cause after reset", 8'h50, 32'h0);
    rd("R1 period after reset", 8'h60, 32'd1000);
    rd("R1 control after reset", 8'h00, 32'h0);

    finish_run();
  end
endmodule